// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block produces the external pin timing for one bus cycle at a time on an 8-bit processor bus. The low address byte and the data byte share one set of pins. A core asks for a cycle by giving a cycle kind, a 16-bit address and a write byte. The sequencer then steps through T-states, one per clock. In the first T-state it presents the low address byte on the shared lines together with an address strobe. In the following states it uses the same lines for data. The high address byte, the memory/IO select and a two-bit status code stay on their pins for the whole cycle.

The length of a cycle depends on its kind. An opcode fetch or an interrupt acknowledge takes four T-states. Memory and I/O reads and writes take three. A slow device can hold the READY input low to add wait states after T2, and the active strobe stays asserted during those states. For read kinds, the byte on the shared lines is captured on the edge that enters T3. It is shown on `rdata` while `done` is high, and `done` is high during the last T-state. A new request may be accepted during that last T-state, so cycles can run back to back with no idle clock between them.

Top module: `mbs_top`

## Requirements
- R1: While `rst_n` is low and after it is released, the block is idle. In that state `idle`=1, `ale`=0, `ad_oe`=0, `rd_n`=`wr_n`=`inta_n`=1, `done`=0 and `rdata`=0.
- R2: An opcode fetch (`req_kind`=0) lasts four T-states, T1 to T4. `rd_n` is low in T2 and T3 only, and T4 has no strobe active.
- R3: A memory read (1), memory write (2), I/O read (3) or I/O write (4) lasts three T-states. `done` is high only in the final T-state of any cycle, and the block is idle on the next clock unless a new request was taken.
- R4: `ale` is high only in T1. In T1 the shared lines are driven (`ad_oe`=1) with address bits 7:0, and no strobe is active.
- R5: `a_hi` carries address bits 15:8 from T1 until the cycle ends, and it does not change while any strobe is active.
- R6: The status code {`s1`,`s0`} is 11 for a fetch, 10 for memory or I/O reads, 01 for memory or I/O writes and 00 for an interrupt acknowledge. It holds for the whole cycle and is 00 while idle.
- R7: READY is sampled on the clock edge that ends T2 and on the edge that ends each wait state. While it is low, wait states follow T2 and the active strobe stays low. T3 follows the first edge at which READY is high. READY has no effect in T3.
- R8: For a fetch, read or acknowledge, `ad_in` is captured on the edge that enters T3. The captured byte is presented on `rdata` while `done` is high, even if `ad_in` changes later.
- R9: In write cycles `ad_oe` stays high from T1 through T3 and `ad_out` carries the write byte after T1. In all other cycles `ad_oe` is low after T1.
- R10: `io_m` is 1 for I/O reads, I/O writes and interrupt acknowledges, and 0 otherwise. No more than one of `rd_n`, `wr_n`, `inta_n` is low at any time. Memory and I/O writes strobe `wr_n`.
- R11: `idle` is high when idle and in the final T-state of a cycle. A request with `req_valid`=1 at a rising edge where `idle`=1 starts T1 on that edge.
- R12: An interrupt acknowledge (5) lasts four T-states. `inta_n` is low in T2 and T3, and `rd_n` stays high.
- R13: A request whose kind code is 6 or 7 is ignored. No cycle starts and `idle` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | T-state clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 3 | Cycle kind code (0..5 valid) |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Byte to write |
| idle | output | 1 | A request may be taken at the next edge |
| ready_in | input | 1 | Device ready, low adds wait states |
| ad_in | input | 8 | Shared lines as read from the pins |
| ale | output | 1 | Address strobe for the low byte |
| ad_out | output | 8 | Value driven on the shared lines |
| ad_oe | output | 1 | Output enable for the shared lines |
| a_hi | output | 8 | High address byte |
| io_m | output | 1 | 1 for I/O space, 0 for memory |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| inta_n | output | 1 | Acknowledge strobe, active low |
| rdata | output | 8 | Captured read byte |
| done | output | 1 | High in the last T-state of a cycle |

## Verification
The assertions check these rules on every clock: `ale` lasts one state and never overlaps a strobe, the shared lines are released whenever a read or acknowledge strobe is low, and only one strobe is active at a time. They also check that address, select and status hold steady under a strobe, that a low READY in T2 or a wait state leads to another wait state with the strobes unchanged, and that `done` falls in T4 or T3 according to the kind. Other properties need known stimulus, so only the bench scenarios can show them. These are the exact value on each pin in each T-state, the byte captured on the edge that enters T3, the exact number of wait states for a given READY pattern, back-to-back acceptance in the final state, and the rejection of unused kind codes.

// File: rtl/mbs_pkg.sv
// Shared types and helpers for the multiplexed bus cycle sequencer.
// Assumes kind codes 0..5 are valid and codes 6 and 7 are unused.
package mbs_pkg;

    typedef enum logic [2:0] {
        K_FETCH = 3'd0,
        K_MRD   = 3'd1,
        K_MWR   = 3'd2,
        K_IORD  = 3'd3,
        K_IOWR  = 3'd4,
        K_INTA  = 3'd5
    } kind_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_T2   = 3'd2,
        ST_TW   = 3'd3,
        ST_T3   = 3'd4,
        ST_T4   = 3'd5
    } tstate_e;

    localparam int unsigned KIND_LAST = 5;

    function automatic logic kind_ok(input logic [2:0] code);
        return code <= 3'(KIND_LAST);
    endfunction

    function automatic logic kind_long(input kind_e k);
        return (k == K_FETCH) || (k == K_INTA);
    endfunction

    function automatic logic kind_write(input kind_e k);
        return (k == K_MWR) || (k == K_IOWR);
    endfunction

    function automatic logic kind_read(input kind_e k);
        return (k == K_FETCH) || (k == K_MRD) || (k == K_IORD);
    endfunction

    function automatic logic kind_io(input kind_e k);
        return (k == K_IORD) || (k == K_IOWR) || (k == K_INTA);
    endfunction

    function automatic logic [1:0] kind_status(input kind_e k);
        logic [1:0] code;
        case (k)
            K_FETCH:        code = 2'b11;
            K_MRD, K_IORD:  code = 2'b10;
            K_MWR, K_IOWR:  code = 2'b01;
            default:        code = 2'b00;
        endcase
        return code;
    endfunction

endpackage

// File: rtl/mbs_sequencer.sv
// T-state sequencer: takes a request, holds it for the cycle and steps
// T1 -> T2 -> (waits) -> T3 [-> T4]. Assumes READY is synchronous to clk.
module mbs_sequencer
    import mbs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              ready_in,
    output tstate_e           st_q,
    output kind_e             kind_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic              last_ph,
    output logic              slot_open
);

    tstate_e st_nxt;
    logic    take;

    // Purpose: flag the final T-state and the acceptance window.
    always_comb begin
        last_ph   = (st_q == ST_T4) || ((st_q == ST_T3) && !kind_long(kind_q));
        slot_open = (st_q == ST_IDLE) || last_ph;
        take      = slot_open && req_valid && kind_ok(req_kind);
    end

    // Purpose: choose the next T-state.
    always_comb begin
        case (st_q)
            ST_IDLE: st_nxt = take ? ST_T1 : ST_IDLE;
            ST_T1:   st_nxt = ST_T2;
            ST_T2,
            ST_TW:   st_nxt = ready_in ? ST_T3 : ST_TW;
            ST_T3: begin
                if (kind_long(kind_q)) st_nxt = ST_T4;
                else                   st_nxt = take ? ST_T1 : ST_IDLE;
            end
            ST_T4:   st_nxt = take ? ST_T1 : ST_IDLE;
            default: st_nxt = ST_IDLE;
        endcase
    end

    // Purpose: state register and request hold registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            kind_q  <= K_FETCH;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            st_q <= st_nxt;
            if (take) begin
                kind_q  <= kind_e'(req_kind);
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
        end
    end

endmodule

// File: rtl/mbs_pin_decode.sv
// Pin decode: turns the registered T-state and the held request into
// pin levels. Purely combinational, so the pins follow the state register.
module mbs_pin_decode
    import mbs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  tstate_e                  st_q,
    input  kind_e                    kind_q,
    input  logic [ADDR_W-1:0]        addr_q,
    input  logic [DATA_W-1:0]        wdata_q,
    output logic                     ale,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    output logic [ADDR_W-DATA_W-1:0] a_hi,
    output logic                     io_m,
    output logic                     s1,
    output logic                     s0,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic                     inta_n
);

    logic active;
    logic strobe_ph;

    // Purpose: phase flags shared by all pin equations.
    always_comb begin
        active    = (st_q != ST_IDLE);
        strobe_ph = (st_q == ST_T2) || (st_q == ST_TW) || (st_q == ST_T3);
    end

    // Purpose: address, select and status pins held for the whole cycle.
    always_comb begin
        a_hi     = active ? addr_q[ADDR_W-1:DATA_W] : '0;
        io_m     = active && kind_io(kind_q);
        {s1, s0} = active ? kind_status(kind_q) : 2'b00;
    end

    // Purpose: strobes and the shared-line driver.
    always_comb begin
        ale    = (st_q == ST_T1);
        rd_n   = !(strobe_ph && kind_read(kind_q));
        wr_n   = !(strobe_ph && kind_write(kind_q));
        inta_n = !(strobe_ph && (kind_q == K_INTA));
        ad_oe  = ale || (strobe_ph && kind_write(kind_q));
        if (ale)        ad_out = addr_q[DATA_W-1:0];
        else if (ad_oe) ad_out = wdata_q;
        else            ad_out = '0;
    end

endmodule

// File: rtl/mbs_rd_capture.sv
// Read byte capture: latches the shared lines on the edge that leaves T2
// or a wait state with READY high (the edge that enters T3), for
// non-write cycles. Assumes ad_in is settled by that edge.
module mbs_rd_capture
    import mbs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tstate_e           st_q,
    input  kind_e             kind_q,
    input  logic              ready_in,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] rdata
);

    logic grab;

    // Purpose: decide whether this edge enters T3 of a read-type cycle.
    always_comb begin
        grab = ((st_q == ST_T2) || (st_q == ST_TW)) && ready_in && !kind_write(kind_q);
    end

    // Purpose: hold the captured byte.
    always_ff @(posedge clk) begin
        if (!rst_n)    rdata <= '0;
        else if (grab) rdata <= ad_in;
    end

endmodule

// File: rtl/mbs_top.sv
// Top of the multiplexed bus cycle sequencer. It joins the sequencer,
// the pin decode and the read capture. Assumes the caller holds
// req_valid until it sees idle high at a rising edge.
module mbs_top
    import mbs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [2:0]               req_kind,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic                     idle,
    input  logic                     ready_in,
    input  logic [DATA_W-1:0]        ad_in,
    output logic                     ale,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    output logic [ADDR_W-DATA_W-1:0] a_hi,
    output logic                     io_m,
    output logic                     s1,
    output logic                     s0,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic                     inta_n,
    output logic [DATA_W-1:0]        rdata,
    output logic                     done
);

    localparam int HI_W = ADDR_W - DATA_W;

    tstate_e           st_q;
    kind_e             kind_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              last_ph;
    logic              slot_open;

    mbs_sequencer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .ready_in  (ready_in),
        .st_q      (st_q),
        .kind_q    (kind_q),
        .addr_q    (addr_q),
        .wdata_q   (wdata_q),
        .last_ph   (last_ph),
        .slot_open (slot_open)
    );

    mbs_pin_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .st_q    (st_q),
        .kind_q  (kind_q),
        .addr_q  (addr_q),
        .wdata_q (wdata_q),
        .ale     (ale),
        .ad_out  (ad_out),
        .ad_oe   (ad_oe),
        .a_hi    (a_hi),
        .io_m    (io_m),
        .s1      (s1),
        .s0      (s0),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .inta_n  (inta_n)
    );

    mbs_rd_capture #(.DATA_W(DATA_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .st_q     (st_q),
        .kind_q   (kind_q),
        .ready_in (ready_in),
        .ad_in    (ad_in),
        .rdata    (rdata)
    );

    // Purpose: completion and acceptance flags at the edge of the block.
    always_comb begin
        done = last_ph;
        idle = slot_open;
    end

endmodule

// File: rtl/mbs_checker.sv
// Protocol checker for mbs_top. It watches the pins and the T-state
// register and is attached to every mbs_top instance by the bind below.
module mbs_checker
    import mbs_pkg::*;
#(
    parameter int HI_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input tstate_e         st_q,
    input kind_e           kind_q,
    input logic            ready_in,
    input logic            ale,
    input logic            ad_oe,
    input logic [HI_W-1:0] a_hi,
    input logic            io_m,
    input logic            s1,
    input logic            s0,
    input logic            rd_n,
    input logic            wr_n,
    input logic            inta_n,
    input logic            done
);

    a_r4_ale_single: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    a_r4_ale_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (rd_n && wr_n && inta_n));

    a_r9_read_release: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !inta_n) |-> !ad_oe);

    a_r5_hold_under_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n || !inta_n) |->
            ($stable(a_hi) && $stable(io_m) && $stable(s1) && $stable(s0)));

    a_r7_wait_state: assert property (@(posedge clk) disable iff (!rst_n)
        (((st_q == ST_T2) || (st_q == ST_TW)) && !ready_in) |=>
            ((st_q == ST_TW) && $stable(rd_n) && $stable(wr_n) && $stable(inta_n)));

    a_r2_long_end: assert property (@(posedge clk) disable iff (!rst_n)
        (done && kind_long(kind_q)) |-> (st_q == ST_T4));

    a_r3_short_end: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !kind_long(kind_q)) |-> (st_q == ST_T3));

    a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~rd_n, ~wr_n, ~inta_n}) <= 1);

    a_r6_write_status: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> ({s1, s0} == 2'b01));

endmodule

bind mbs_top mbs_checker #(.HI_W(HI_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .st_q     (st_q),
    .kind_q   (kind_q),
    .ready_in (ready_in),
    .ale      (ale),
    .ad_oe    (ad_oe),
    .a_hi     (a_hi),
    .io_m     (io_m),
    .s1       (s1),
    .s0       (s0),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .inta_n   (inta_n),
    .done     (done)
);

// File: tb/mbs_top_test.sv
`timescale 1ns/1ps
// Bench for mbs_top: a behavioural per-T-state model predicts every pin
// and compares it on each falling edge.
module mbs_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = 3'd0;
    logic [15:0] req_addr = 16'h0;
    logic [7:0]  req_wdata = 8'h0;
    logic        ready_in = 1'b1;
    logic [7:0]  ad_in = 8'h0;
    logic        idle, ale, ad_oe, io_m, s1, s0, rd_n, wr_n, inta_n, done;
    logic [7:0]  ad_out, a_hi, rdata;

    int nchk = 0;
    int nerr = 0;

    mbs_top uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .idle(idle),
        .ready_in(ready_in), .ad_in(ad_in), .ale(ale), .ad_out(ad_out),
        .ad_oe(ad_oe), .a_hi(a_hi), .io_m(io_m), .s1(s1), .s0(s0),
        .rd_n(rd_n), .wr_n(wr_n), .inta_n(inta_n), .rdata(rdata), .done(done)
    );

    always #4 clk = ~clk;

    task automatic chk(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    task automatic present(input int k, input logic [15:0] a, input logic [7:0] wd);
        req_valid = 1'b1;
        req_kind  = 3'(k);
        req_addr  = a;
        req_wdata = wd;
    endtask

    // Checks the quiet pin set at a falling edge (R1, R3, R13).
    task automatic idle_check(input string rq);
        chk(rq, "idle", idle, 1);
        chk(rq, "ale", ale, 0);
        chk(rq, "ad_oe", ad_oe, 0);
        chk(rq, "strobes", {rd_n, wr_n, inta_n}, 3'b111);
        chk(rq, "done", done, 0);
        chk(rq, "io_m", io_m, 0);
        chk(rq, "status", {s1, s0}, 2'b00);
    endtask

    // Model of one cycle; the request must be presented before the edge
    // that follows the call. Stage codes: 1,2,3,4 and 9 for a wait state.
    task automatic run_cycle(input int k, input logic [15:0] a, input logic [7:0] wd,
                             input int nw, input logic [7:0] rb, input bit chain,
                             input int nk, input logic [15:0] na, input logic [7:0] nwd);
        int  stg = 1;
        int  w = nw;
        bit  wr  = (k == 2) || (k == 4);
        bit  rdk = (k == 0) || (k == 1) || (k == 3);
        bit  lng = (k == 0) || (k == 5);
        bit  io  = (k == 3) || (k == 4) || (k == 5);
        logic [1:0] sts = (k == 0) ? 2'b11 : ((k == 1) || (k == 3)) ? 2'b10 : wr ? 2'b01 : 2'b00;
        string tg = (k == 5) ? "R12" : lng ? "R2" : "R3";
        ad_in = 8'h00;
        forever begin
            bit strb, last;
            string st_tg;
            @(negedge clk);
            strb  = (stg == 2) || (stg == 9) || (stg == 3);
            last  = lng ? (stg == 4) : (stg == 3);
            st_tg = (stg == 9) ? "R7" : tg;
            chk("R4", "ale", ale, stg == 1);
            if (stg == 1) begin
                chk("R4", "ad_oe in T1", ad_oe, 1);
                chk("R4", "low addr", ad_out, a[7:0]);
            end else begin
                chk("R9", "ad_oe after T1", ad_oe, wr && strb);
                if (wr && strb) chk("R9", "write byte", ad_out, wd);
            end
            chk("R5", "a_hi", a_hi, a[15:8]);
            chk("R10", "io_m", io_m, io);
            chk("R6", "status", {s1, s0}, sts);
            chk(st_tg, "rd_n", rd_n, !(strb && rdk));
            chk((stg == 9) ? "R7" : "R10", "wr_n", wr_n, !(strb && wr));
            chk((stg == 9) ? "R7" : "R12", "inta_n", inta_n, !(strb && k == 5));
            chk("R3", "done", done, last);
            chk("R11", "idle", idle, last);
            if (last && !wr) chk("R8", "rdata", rdata, rb);
            if (last) begin
                if (chain) present(nk, na, nwd);
                else req_valid = 1'b0;
                ready_in = 1'b1;
                return;
            end
            case (stg)
                1: begin
                    req_valid = 1'b0;
                    stg = 2;
                end
                2: begin
                    ready_in = (w == 0);
                    ad_in = rb;
                    stg = (w == 0) ? 3 : 9;
                end
                9: begin
                    w--;
                    ready_in = (w == 0);
                    stg = (w == 0) ? 3 : 9;
                end
                default: begin
                    ad_in = ~rb;
                    ready_in = 1'b0;   // READY is ignored in T3 (R7)
                    stg = 4;
                end
            endcase
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        nchk++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        idle_check("R1");
        chk("R1", "rdata", rdata, 0);
        rst_n = 1'b1;
        @(negedge clk);
        idle_check("R1");

        // R13: unused kind codes never start a cycle
        present(6, 16'h1234, 8'h00);
        @(negedge clk);
        idle_check("R13");
        present(7, 16'hFFFF, 8'h00);
        @(negedge clk);
        idle_check("R13");
        req_valid = 1'b0;

        // R2 opcode fetch, no waits
        present(0, 16'h1234, 8'h00);
        run_cycle(0, 16'h1234, 8'h00, 0, 8'h3E, 0, 0, 0, 0);
        @(negedge clk); idle_check("R3");

        // R3 memory read
        present(1, 16'hABCD, 8'h00);
        run_cycle(1, 16'hABCD, 8'h00, 0, 8'h5A, 0, 0, 0, 0);
        @(negedge clk); idle_check("R3");

        // R9 memory write
        present(2, 16'h00FF, 8'hC3);
        run_cycle(2, 16'h00FF, 8'hC3, 0, 8'h00, 0, 0, 0, 0);
        @(negedge clk); idle_check("R3");

        // R7 I/O read with two wait states
        present(3, 16'h4242, 8'h00);
        run_cycle(3, 16'h4242, 8'h00, 2, 8'h81, 0, 0, 0, 0);
        @(negedge clk); idle_check("R7");

        // R7 I/O write with one wait state
        present(4, 16'h9966, 8'hA5);
        run_cycle(4, 16'h9966, 8'hA5, 1, 8'h00, 0, 0, 0, 0);
        @(negedge clk); idle_check("R7");

        // R12 interrupt acknowledge
        present(5, 16'h8001, 8'h00);
        run_cycle(5, 16'h8001, 8'h00, 0, 8'hFF, 0, 0, 0, 0);
        @(negedge clk); idle_check("R12");

        // R7 fetch stretched by three waits
        present(0, 16'h7E01, 8'h00);
        run_cycle(0, 16'h7E01, 8'h00, 3, 8'h17, 0, 0, 0, 0);
        @(negedge clk); idle_check("R7");

        // R11 back-to-back: write, read, fetch with no idle clock
        present(2, 16'h2000, 8'h11);
        run_cycle(2, 16'h2000, 8'h11, 0, 8'h00, 1, 1, 16'h3001, 8'h00);
        run_cycle(1, 16'h3001, 8'h00, 1, 8'h6C, 1, 0, 16'h3002, 8'h00);
        run_cycle(0, 16'h3002, 8'h00, 0, 8'hD2, 0, 0, 0, 0);
        @(negedge clk); idle_check("R11");

        report();
    end

endmodule